// File: doc/BRIEF.md
# GSM Channel to Synthesizer Word Generator

This block turns a GSM channel number, together with an uplink/downlink select, into everything a fractional-N radio synthesizer needs. It produces the carrier frequency in units of 0.1 MHz, a band code, the integer and fractional divider values, and a packed control word. The packed word is ready to be shifted into a radio by some other block. Only integer arithmetic is used. The divider assumes a 26 MHz reference behind a fixed divide-by-two, so the integer divider is the VCO frequency divided by 52 MHz. The fractional part is expressed in 130ths.

A request is offered with `in_valid` and taken when `in_ready` is high. Decoding is done in a first pipeline stage and the divider arithmetic in a second. The results therefore appear two clock edges after acceptance. While a request is in flight, `in_ready` stays low. Once `out_valid` rises, the results stay on the outputs, unchanged, until the next request is accepted. Accepting a new request drops `out_valid` at once.

Top module: `chsyn_word_gen`

## Requirements
- R1: The channel input is 16 bits. Bit 15 selects the PCS band. Bits 14:12 are flags that have no effect on any output. Range decoding uses only bits 11:0 (n).
- R2: Channels 0..124 give an uplink of 8900+2n. Channels 955..1023 give an uplink of 8900+2(n-1024). Both use band code 1 and a downlink 450 higher.
- R3: Channels 128..251 give an uplink of 8242+2(n-128), with band code 0 and a downlink 450 higher. Channels 512..885 give an uplink of 17102+2(n-512), with band code 2 and a downlink 950 higher.
- R4: With bit 15 set, the uplink is (18502+2(n-512)) mod 65536 and the downlink is 800 higher, with band code 3, whatever the value of n.
- R5: Four bands have no synthesizer support, and each still reports its frequency. These are:
  - channels 259..293: 4506+2(n-259), downlink +100, band code 4;
  - channels 306..340: 4790+2(n-306), downlink +100, band code 5;
  - channels 350..425: 8060+2(n-350), downlink +450, band code 6;
  - channels 438..511: 7472+2(n-438), downlink +300, band code 7.
  For these bands the invalid flag is 1, the dividers are 0 and the packed word is 0.
- R6: Any other channel gives frequency 0xFFFF, band code 2 and invalid flag 1. The dividers and the word are still derived from that frequency.
- R7: The VCO frequency is 4x the carrier for band codes 0 and 1, and 2x for band codes 2 and 3. The integer divider is fvco/520 and the fractional divider is fvco*130/520 - Nint*130, with fvco in 0.1 MHz units.
- R8: The packed word, 24 bits, carries:
  - Nfrac in bits 7:0;
  - the low 7 bits of Nint in bits 14:8;
  - the band code in bits 16:15;
  - a transmit bit at bit 17 and a buffer-mode bit at bit 18, both set only for an uplink request in band 0 or 1.
  All other bits are 0.
- R9: The out-of-range flag is 1 exactly when Nint exceeds the parameter NINT_LIMIT (default 127).
- R10: A request is accepted when both `in_valid` and `in_ready` are high. After acceptance, `in_ready` and `out_valid` are low for one cycle and then both are high. Inputs that are offered while a request is busy, or while `in_valid` is low, do not change the held results.
- R11: During reset, `out_valid` is 0, `in_ready` is 1 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can accept a request |
| in_chan | input | 16 | Channel number with flag bits |
| in_uplink | input | 1 | 1 selects uplink, 0 selects downlink |
| out_valid | output | 1 | Results are present and held |
| out_band | output | 3 | Band code |
| out_freq | output | 16 | Carrier frequency in 0.1 MHz |
| out_nint | output | 9 | Integer divider, full width |
| out_nfrac | output | 8 | Fractional divider in 130ths |
| out_word | output | 24 | Packed synthesizer control word |
| out_oor | output | 1 | Integer divider beyond its limit |
| out_invalid | output | 1 | Channel unmapped or band without synthesizer |

## Verification
The bench builds two copies of the block side by side, driven by the same inputs.

The first copy uses the default parameters. With those defaults, no mapped channel can push Nint past 127, so the out-of-range flag is only reached through unmapped channels.

The second copy sets NINT_LIMIT to 70. This places the flag's boundary inside the normal bands: a mapped channel yielding Nint 70 must stay clear, and channels yielding 71 or more must raise it. That makes the strict comparison observable on real carriers.

// File: rtl/chsyn_pkg.sv
package chsyn_pkg;

    typedef enum logic [2:0] {
        BND_850  = 3'd0,
        BND_900  = 3'd1,
        BND_1800 = 3'd2,
        BND_1900 = 3'd3,
        BND_450  = 3'd4,
        BND_480  = 3'd5,
        BND_810  = 3'd6,
        BND_750  = 3'd7
    } band_e;

    // Flag bits at the top of the channel word
    localparam int FLAG_W     = 4;
    localparam int NUM_RANGES = 8;

    // Range table: low edge, high edge, uplink value at n = 0, duplex offset
    localparam int unsigned RNG_LO  [NUM_RANGES] = '{0,    955,  128,  512,   259,  306,  350,  438};
    localparam int unsigned RNG_HI  [NUM_RANGES] = '{124,  1023, 251,  885,   293,  340,  425,  511};
    localparam int unsigned RNG_ORG [NUM_RANGES] = '{8900, 6852, 7986, 16078, 3988, 4178, 7360, 6596};
    localparam int unsigned RNG_DUP [NUM_RANGES] = '{450,  450,  450,  950,   100,  100,  450,  300};
    localparam band_e       RNG_BND [NUM_RANGES] = '{BND_900, BND_900, BND_850, BND_1800,
                                                     BND_450, BND_480, BND_810, BND_750};

    // PCS: 18502 + 2(n - 512) expressed as origin + 2n
    localparam int unsigned PCS_ORG = 17478;
    localparam int unsigned PCS_DUP = 800;

endpackage

// File: rtl/chsyn_band_decode.sv
module chsyn_band_decode
    import chsyn_pkg::*;
#(
    parameter int CH_W   = 16,
    parameter int FREQ_W = 16
) (
    input  logic [CH_W-1:0]   chan,
    input  logic              uplink,
    output band_e             band,
    output logic [FREQ_W-1:0] freq,
    output logic              unmapped
);

    localparam int IDX_W = CH_W - FLAG_W;

    logic [31:0]       n32;
    logic              pcs;
    logic [FREQ_W-1:0] freq_pcs;
    logic [NUM_RANGES-1:0] hit;
    logic [FREQ_W-1:0] fq [NUM_RANGES];

    assign n32 = 32'(chan[IDX_W-1:0]);
    assign pcs = chan[CH_W-1];

    assign freq_pcs = FREQ_W'(PCS_ORG + 2 * n32 + (uplink ? 32'd0 : PCS_DUP));

    // One comparator pair and one adder per band range
    for (genvar g = 0; g < NUM_RANGES; g++) begin : g_rng
        assign hit[g] = (n32 >= RNG_LO[g]) && (n32 <= RNG_HI[g]);
        assign fq[g]  = FREQ_W'(RNG_ORG[g] + 2 * n32 + (uplink ? 32'd0 : RNG_DUP[g]));
    end

    always_comb begin
        band     = BND_1800;
        freq     = '1;
        unmapped = 1'b1;
        if (pcs) begin
            band     = BND_1900;
            freq     = freq_pcs;
            unmapped = 1'b0;
        end else begin
            // Ranges are disjoint, so scan order carries no priority
            for (int g = 0; g < NUM_RANGES; g++) begin
                if (hit[g]) begin
                    band     = RNG_BND[g];
                    freq     = fq[g];
                    unmapped = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/chsyn_synth_div.sv
module chsyn_synth_div
    import chsyn_pkg::*;
#(
    parameter int FREQ_W     = 16,
    parameter int NINT_W     = 9,
    parameter int NFRAC_W    = 8,
    parameter int NINT_LIMIT = 127,
    parameter int REF10      = 260,
    parameter int FRAC_DEN   = 130
) (
    input  band_e              band,
    input  logic [FREQ_W-1:0]  freq,
    output logic               has_synth,
    output logic [NINT_W-1:0]  nint,
    output logic [NFRAC_W-1:0] nfrac,
    output logic               oor
);

    localparam int FVCO_W = FREQ_W + 2;
    localparam int PROD_W = FVCO_W + $clog2(FRAC_DEN) + 1;
    localparam int DIV    = 2 * REF10;

    logic [FVCO_W-1:0] fvco;
    logic [FVCO_W-1:0] nint_full;
    logic [PROD_W-1:0] scaled;
    logic [PROD_W-1:0] frac_full;

    // VCO multiple: x4 for low bands, x2 for high bands, none otherwise
    always_comb begin
        case (band)
            BND_850, BND_900: begin
                fvco      = {freq, 2'b00};
                has_synth = 1'b1;
            end
            BND_1800, BND_1900: begin
                fvco      = {1'b0, freq, 1'b0};
                has_synth = 1'b1;
            end
            default: begin
                fvco      = '0;
                has_synth = 1'b0;
            end
        endcase
    end

    assign nint_full = fvco / FVCO_W'(DIV);
    assign scaled    = (PROD_W'(fvco) * PROD_W'(FRAC_DEN)) / PROD_W'(DIV);
    assign frac_full = scaled - PROD_W'(nint_full) * PROD_W'(FRAC_DEN);

    assign nint  = NINT_W'(nint_full);
    assign nfrac = NFRAC_W'(frac_full);
    assign oor   = nint_full > FVCO_W'(NINT_LIMIT);

endmodule

// File: rtl/chsyn_word_gen.sv
module chsyn_word_gen
    import chsyn_pkg::*;
#(
    parameter int CH_W        = 16,
    parameter int FREQ_W      = 16,
    parameter int NINT_W      = 9,
    parameter int NINT_PACK_W = 7,
    parameter int NFRAC_W     = 8,
    parameter int WORD_W      = 24,
    parameter int NINT_LIMIT  = 127,
    parameter int REF10       = 260,
    parameter int FRAC_DEN    = 130
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [CH_W-1:0]    in_chan,
    input  logic               in_uplink,
    output logic               out_valid,
    output logic [2:0]         out_band,
    output logic [FREQ_W-1:0]  out_freq,
    output logic [NINT_W-1:0]  out_nint,
    output logic [NFRAC_W-1:0] out_nfrac,
    output logic [WORD_W-1:0]  out_word,
    output logic               out_oor,
    output logic               out_invalid
);

    localparam int BAND_PACK_W = 2;
    localparam int NINT_LSB    = NFRAC_W;
    localparam int BAND_LSB    = NINT_LSB + NINT_PACK_W;
    localparam int TX_BIT      = BAND_LSB + BAND_PACK_W;
    localparam int BUF_BIT     = TX_BIT + 1;

    typedef struct packed {
        logic               busy;
        logic               ul;
        band_e              band;
        logic [FREQ_W-1:0]  freq;
        logic               unm;
        logic               ovld;
        band_e              o_band;
        logic [FREQ_W-1:0]  o_freq;
        logic [NINT_W-1:0]  o_nint;
        logic [NFRAC_W-1:0] o_nfrac;
        logic [WORD_W-1:0]  o_word;
        logic               o_oor;
        logic               o_inv;
    } st_t;

    st_t st_d, st_q;

    band_e              dec_band;
    logic [FREQ_W-1:0]  dec_freq;
    logic               dec_unm;
    logic               div_ok;
    logic [NINT_W-1:0]  div_nint;
    logic [NFRAC_W-1:0] div_nfrac;
    logic               div_oor;
    logic [WORD_W-1:0]  word_d;
    logic               accept;

    chsyn_band_decode #(
        .CH_W   (CH_W),
        .FREQ_W (FREQ_W)
    ) u_dec (
        .chan     (in_chan),
        .uplink   (in_uplink),
        .band     (dec_band),
        .freq     (dec_freq),
        .unmapped (dec_unm)
    );

    // Second stage works on the registered decode
    chsyn_synth_div #(
        .FREQ_W     (FREQ_W),
        .NINT_W     (NINT_W),
        .NFRAC_W    (NFRAC_W),
        .NINT_LIMIT (NINT_LIMIT),
        .REF10      (REF10),
        .FRAC_DEN   (FRAC_DEN)
    ) u_div (
        .band      (st_q.band),
        .freq      (st_q.freq),
        .has_synth (div_ok),
        .nint      (div_nint),
        .nfrac     (div_nfrac),
        .oor       (div_oor)
    );

    assign accept = in_valid && !st_q.busy;

    always_comb begin
        word_d = '0;
        if (div_ok) begin
            word_d[NFRAC_W-1:0]               = div_nfrac;
            word_d[NINT_LSB +: NINT_PACK_W]   = div_nint[NINT_PACK_W-1:0];
            word_d[BAND_LSB +: BAND_PACK_W]   = st_q.band[BAND_PACK_W-1:0];
            if (st_q.ul && (st_q.band == BND_850 || st_q.band == BND_900)) begin
                word_d[TX_BIT]  = 1'b1;
                word_d[BUF_BIT] = 1'b1;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.ul   = in_uplink;
            st_d.band = dec_band;
            st_d.freq = dec_freq;
            st_d.unm  = dec_unm;
            st_d.ovld = 1'b0;
        end else if (st_q.busy) begin
            st_d.busy    = 1'b0;
            st_d.ovld    = 1'b1;
            st_d.o_band  = st_q.band;
            st_d.o_freq  = st_q.freq;
            st_d.o_nint  = div_nint;
            st_d.o_nfrac = div_nfrac;
            st_d.o_word  = word_d;
            st_d.o_oor   = div_oor;
            st_d.o_inv   = st_q.unm || !div_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready    = !st_q.busy;
    assign out_valid   = st_q.ovld;
    assign out_band    = st_q.o_band;
    assign out_freq    = st_q.o_freq;
    assign out_nint    = st_q.o_nint;
    assign out_nfrac   = st_q.o_nfrac;
    assign out_word    = st_q.o_word;
    assign out_oor     = st_q.o_oor;
    assign out_invalid = st_q.o_inv;

endmodule

// File: rtl/chsyn_word_gen_chk.sv
module chsyn_word_gen_chk #(
    parameter int FREQ_W      = 16,
    parameter int NINT_W      = 9,
    parameter int NINT_PACK_W = 7,
    parameter int NFRAC_W     = 8,
    parameter int WORD_W      = 24,
    parameter int NINT_LIMIT  = 127,
    parameter int FRAC_DEN    = 130
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic [2:0]         out_band,
    input logic [FREQ_W-1:0]  out_freq,
    input logic [NINT_W-1:0]  out_nint,
    input logic [NFRAC_W-1:0] out_nfrac,
    input logic [WORD_W-1:0]  out_word,
    input logic               out_oor,
    input logic               out_invalid
);

    localparam int TX_BIT  = NFRAC_W + NINT_PACK_W + 2;
    localparam int BUF_BIT = TX_BIT + 1;

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!in_ready && !out_valid));

    assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready) |=> (in_ready && out_valid));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !in_valid) |=> (out_valid && $stable(out_word) && $stable(out_freq)));

    assert_nosynth_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_band >= 3'd4) |-> (out_invalid && out_word == '0 && out_nint == '0));

    assert_unmapped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_freq == '1) |-> (out_invalid && out_band == 3'd2));

    assert_frac_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_invalid) |-> (32'(out_nfrac) < FRAC_DEN));

    assert_txbits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_word[TX_BIT] || out_word[BUF_BIT])) |-> (out_band <= 3'd1));

    assert_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_oor) |-> (32'(out_nint) <= NINT_LIMIT));

endmodule

bind chsyn_word_gen chsyn_word_gen_chk #(
    .FREQ_W      (FREQ_W),
    .NINT_W      (NINT_W),
    .NINT_PACK_W (NINT_PACK_W),
    .NFRAC_W     (NFRAC_W),
    .WORD_W      (WORD_W),
    .NINT_LIMIT  (NINT_LIMIT),
    .FRAC_DEN    (FRAC_DEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_band    (out_band),
    .out_freq    (out_freq),
    .out_nint    (out_nint),
    .out_nfrac   (out_nfrac),
    .out_word    (out_word),
    .out_oor     (out_oor),
    .out_invalid (out_invalid)
);

// File: tb/sim_chsyn_word_gen.sv
module sim_chsyn_word_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_chan = '0;
    logic        in_uplink = 1'b0;

    logic        rdy0, vld0, oor0, inv0;
    logic [2:0]  band0;
    logic [15:0] freq0;
    logic [8:0]  nint0;
    logic [7:0]  nfrac0;
    logic [23:0] word0;

    logic        rdy1, vld1, oor1, inv1;
    logic [2:0]  band1;
    logic [15:0] freq1;
    logic [8:0]  nint1;
    logic [7:0]  nfrac1;
    logic [23:0] word1;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    chsyn_word_gen u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (rdy0),
        .in_chan (in_chan), .in_uplink (in_uplink), .out_valid (vld0),
        .out_band (band0), .out_freq (freq0), .out_nint (nint0),
        .out_nfrac (nfrac0), .out_word (word0), .out_oor (oor0),
        .out_invalid (inv0)
    );

    chsyn_word_gen #(.NINT_LIMIT (70)) u1 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (rdy1),
        .in_chan (in_chan), .in_uplink (in_uplink), .out_valid (vld1),
        .out_band (band1), .out_freq (freq1), .out_nint (nint1),
        .out_nfrac (nfrac1), .out_word (word1), .out_oor (oor1),
        .out_invalid (inv1)
    );

    typedef struct packed {
        logic [15:0] ch;
        logic        ul;
        logic [3:0]  grp;
        logic [15:0] freq;
        logic [2:0]  band;
        logic [8:0]  nint;
        logic [7:0]  nfrac;
        logic [23:0] word;
        logic        oor;
        logic        inv;
        logic        oor70;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{16'h0000, 1'b1, 4'd2, 16'd8900,  3'd1, 9'd68,  8'd60,  24'h06C43C, 1'b0, 1'b0, 1'b0},
        '{16'h0000, 1'b0, 4'd2, 16'd9350,  3'd1, 9'd71,  8'd120, 24'h00C778, 1'b0, 1'b0, 1'b1},
        '{16'h007C, 1'b1, 4'd2, 16'd9148,  3'd1, 9'd70,  8'd48,  24'h06C630, 1'b0, 1'b0, 1'b0},
        '{16'h03CF, 1'b0, 4'd2, 16'd9252,  3'd1, 9'd71,  8'd22,  24'h00C716, 1'b0, 1'b0, 1'b1},
        '{16'h03BB, 1'b1, 4'd2, 16'd8762,  3'd1, 9'd67,  8'd52,  24'h06C334, 1'b0, 1'b0, 1'b0},
        '{16'h03FF, 1'b0, 4'd2, 16'd9348,  3'd1, 9'd71,  8'd118, 24'h00C776, 1'b0, 1'b0, 1'b1},
        '{16'h0080, 1'b1, 4'd3, 16'd8242,  3'd0, 9'd63,  8'd52,  24'h063F34, 1'b0, 1'b0, 1'b0},
        '{16'h00FB, 1'b0, 4'd3, 16'd8938,  3'd0, 9'd68,  8'd98,  24'h004462, 1'b0, 1'b0, 1'b0},
        '{16'h0200, 1'b1, 4'd3, 16'd17102, 3'd2, 9'd65,  8'd101, 24'h014165, 1'b0, 1'b0, 1'b0},
        '{16'h0375, 1'b0, 4'd3, 16'd18798, 3'd2, 9'd72,  8'd39,  24'h014827, 1'b0, 1'b0, 1'b1},
        '{16'h8200, 1'b1, 4'd4, 16'd18502, 3'd3, 9'd71,  8'd21,  24'h01C715, 1'b0, 1'b0, 1'b1},
        '{16'h8320, 1'b0, 4'd4, 16'd19878, 3'd3, 9'd76,  8'd59,  24'h01CC3B, 1'b0, 1'b0, 1'b1},
        '{16'h8000, 1'b1, 4'd4, 16'd17478, 3'd3, 9'd67,  8'd29,  24'h01C31D, 1'b0, 1'b0, 1'b0},
        '{16'h100A, 1'b1, 4'd1, 16'd8920,  3'd1, 9'd68,  8'd80,  24'h06C450, 1'b0, 1'b0, 1'b0},
        '{16'h7005, 1'b0, 4'd1, 16'd9360,  3'd1, 9'd72,  8'd0,   24'h00C800, 1'b0, 1'b0, 1'b1},
        '{16'h0103, 1'b1, 4'd5, 16'd4506,  3'd4, 9'd0,   8'd0,   24'h000000, 1'b0, 1'b1, 1'b0},
        '{16'h0154, 1'b0, 4'd5, 16'd4958,  3'd5, 9'd0,   8'd0,   24'h000000, 1'b0, 1'b1, 1'b0},
        '{16'h015E, 1'b1, 4'd5, 16'd8060,  3'd6, 9'd0,   8'd0,   24'h000000, 1'b0, 1'b1, 1'b0},
        '{16'h01FF, 1'b0, 4'd5, 16'd7918,  3'd7, 9'd0,   8'd0,   24'h000000, 1'b0, 1'b1, 1'b0},
        '{16'h007D, 1'b1, 4'd6, 16'hFFFF,  3'd2, 9'd252, 8'd7,   24'h017C07, 1'b1, 1'b1, 1'b1},
        '{16'h0376, 1'b0, 4'd6, 16'hFFFF,  3'd2, 9'd252, 8'd7,   24'h017C07, 1'b1, 1'b1, 1'b1},
        '{16'h0FFF, 1'b1, 4'd6, 16'hFFFF,  3'd2, 9'd252, 8'd7,   24'h017C07, 1'b1, 1'b1, 1'b1}
    };

    function automatic string req_of(input logic [3:0] g);
        case (g)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Offer one request; return at the falling edge after results land
    task automatic request(input logic [15:0] ch, input logic ul);
        @(negedge clk);
        in_valid  = 1'b1;
        in_chan   = ch;
        in_uplink = ul;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: state held in reset
        repeat (3) @(negedge clk);
        chk("R11", "out_valid in reset", 32'(vld0), 32'd0);
        chk("R11", "in_ready in reset", 32'(rdy0), 32'd1);
        chk("R11", "word in reset", 32'(word0), 32'd0);
        chk("R11", "freq in reset", 32'(freq0), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "out_valid after reset", 32'(vld0), 32'd0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            request(VEC[i].ch, VEC[i].ul);
            chk(req_of(VEC[i].grp), "freq",    32'(freq0),  32'(VEC[i].freq));
            chk(req_of(VEC[i].grp), "band",    32'(band0),  32'(VEC[i].band));
            chk(req_of(VEC[i].grp), "invalid", 32'(inv0),   32'(VEC[i].inv));
            chk("R7", "nint",  32'(nint0),  32'(VEC[i].nint));
            chk("R7", "nfrac", 32'(nfrac0), 32'(VEC[i].nfrac));
            chk("R8", "word",  32'(word0),  32'(VEC[i].word));
            chk("R9", "oor default limit", 32'(oor0), 32'(VEC[i].oor));
            chk("R9", "oor limit 70",      32'(oor1), 32'(VEC[i].oor70));
            chk("R10", "out_valid", 32'(vld0), 32'd1);
        end

        // R10: handshake timing, and a request offered while busy is ignored
        @(negedge clk);
        in_valid  = 1'b1;
        in_chan   = 16'h0000;
        in_uplink = 1'b1;
        @(negedge clk);
        chk("R10", "in_ready while busy", 32'(rdy0), 32'd0);
        chk("R10", "out_valid while busy", 32'(vld0), 32'd0);
        in_chan   = 16'h0200;
        in_uplink = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10", "out_valid after two edges", 32'(vld0), 32'd1);
        chk("R10", "in_ready after two edges", 32'(rdy0), 32'd1);
        chk("R10", "busy-time request ignored", 32'(word0), 32'h06C43C);

        // R10: inputs moving without valid leave results held
        in_chan   = 16'h0375;
        in_uplink = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10", "word held", 32'(word0), 32'h06C43C);
        chk("R10", "freq held", 32'(freq0), 32'd8900);
        chk("R10", "valid held", 32'(vld0), 32'd1);

        // R8: same channel, downlink drops transmit and buffer bits
        request(16'h0080, 1'b0);
        chk("R8", "tx/buf bits clear on downlink", 32'(word0[18:17]), 32'd0);
        chk("R3", "850 downlink freq", 32'(freq0), 32'd8692);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule